// File: doc/BRIEF.md
# Four-Channel Shared-Counter PWM Generator

This block drives four pulse-width modulated outputs from one free-running resolution counter. A tick enable advances the counter. The tick should run at the wanted PWM frequency multiplied by the number of counter steps. Each period starts when the counter rolls over to zero. At that point every channel with a non-zero duty goes high. A channel goes low when the counter reaches that channel's duty value.

Each channel has its own push-button input. A press raises that channel's duty by one tenth of full scale. After the top step it returns to zero. The buttons may be asynchronous. Each one passes through a two-flop synchronizer and a rising-edge detector, so one press counts once however long it is held.

A new duty value waits in a pending register. It is copied into the live register only at the rollover, so a running period is never shortened or stretched. The block has no data stream, so all pins are plain control and status signals with no handshake.

Top module: `pwm_multi_gen`

## Requirements
- R1: While rst_n is low, and after it is released, every step index, every duty value and the counter are zero, so all pwm outputs are low.
- R2: The counter advances by one on each clock edge where tick is high. It rolls from 255 to 0, so a period lasts exactly 256 ticks.
- R3: Within a period, pwm[i] is high while the counter value is below the live duty of channel i, and low from that value to the end of the period.
- R4: A rising edge on btn[i], after synchronization, raises the step index of channel i by exactly one. A button held high for many cycles counts as a single press.
- R5: The step index of a channel runs from 0 to 10. Its duty equals floor(index * 256 / 10), which gives 0, 25, 51, 76, 102, 128, 153, 179, 204, 230 and 256. A press at index 10 returns the index to 0.
- R6: A duty of 0 keeps the output low for the whole period. Index 10, a duty of 256, keeps it high for the whole period.
- R7: A duty change made during a period has no effect on that period. It takes effect from the next rollover of the counter.
- R8: A press on one channel changes only that channel's duty. The other channels' outputs keep their waveforms.
- R9: While tick is low, the counter holds its value and every pwm output holds its level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Counter advance enable, synchronous to clk |
| btn | input | 4 | Per-channel push buttons, asynchronous, active high |
| pwm | output | 4 | Per-channel PWM outputs |

## Verification
The assertions take for granted that tick is synchronous to clk. They also assume that a button stays high long enough to pass the two synchronizer flops, and then stays low long enough before the next press. Under those conditions every accepted press moves the step index by exactly one, and an output can only rise at a counter rollover. The bench meets these conditions by changing inputs only on the falling clock edge and holding each press for at least three cycles. It also leaves a gap of several cycles between presses.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  // Duty value for a step index: floor(idx * full / steps)
  function automatic int unsigned step_to_duty(input int unsigned idx,
                                               input int unsigned full,
                                               input int unsigned steps);
    return (idx * full) / steps;
  endfunction
endpackage

// File: rtl/pwm_btn_sync.sv
module pwm_btn_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic btn_raw,
  output logic press
);
  logic s1, s2, s3;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1 <= 1'b0;
      s2 <= 1'b0;
      s3 <= 1'b0;
    end else begin
      s1 <= btn_raw;
      s2 <= s1;
      s3 <= s2;
    end
  end

  assign press = s2 & ~s3;

  // A press pulse never lasts two cycles in a row
  AST_PRESS_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    press |=> !press); // R4
endmodule

// File: rtl/pwm_duty_step.sv
module pwm_duty_step #(
  parameter int RES_W = 8,
  parameter int STEPS = 10
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           press,
  output logic [RES_W:0] duty_pend
);
  import pwm_pkg::*;
  localparam int FULL   = 1 << RES_W;
  localparam int IDX_W  = $clog2(STEPS + 1);
  localparam int DUTY_W = RES_W + 1;

  logic [IDX_W-1:0] idx, idx_nxt;

  always_comb begin
    if (idx == IDX_W'(STEPS)) idx_nxt = '0;
    else                      idx_nxt = idx + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx       <= '0;
      duty_pend <= '0;
    end else if (press) begin
      idx       <= idx_nxt;
      duty_pend <= DUTY_W'(step_to_duty(int'(idx_nxt), FULL, STEPS));
    end
  end

  AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    idx <= IDX_W'(STEPS)); // R5
  AST_IDX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !press |=> $stable(idx)); // R4
  AST_DUTY_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    duty_pend <= DUTY_W'(FULL)); // R6
endmodule

// File: rtl/pwm_res_counter.sv
module pwm_res_counter #(
  parameter int RES_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  output logic [RES_W-1:0] cnt,
  output logic             wrap
);
  always_ff @(posedge clk) begin
    if (!rst_n)    cnt <= '0;
    else if (tick) cnt <= cnt + 1'b1;
  end

  assign wrap = tick && (cnt == {RES_W{1'b1}});

  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt)); // R9
  AST_CNT_ROLL: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (cnt == '0)); // R2
endmodule

// File: rtl/pwm_chan_out.sv
module pwm_chan_out #(
  parameter int RES_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wrap,
  input  logic [RES_W-1:0] cnt,
  input  logic [RES_W:0]   duty_pend,
  output logic             pwm
);
  logic [RES_W:0] duty_live;

  always_ff @(posedge clk) begin
    if (!rst_n)    duty_live <= '0;
    else if (wrap) duty_live <= duty_pend;
  end

  assign pwm = ({1'b0, cnt} < duty_live);

  AST_LIVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap |=> $stable(duty_live)); // R7
  AST_RISE_AT_ROLL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwm) |-> (cnt == '0)); // R3
endmodule

// File: rtl/pwm_multi_gen.sv
module pwm_multi_gen #(
  parameter int NCH   = 4,
  parameter int RES_W = 8,
  parameter int STEPS = 10
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           tick,
  input  logic [NCH-1:0] btn,
  output logic [NCH-1:0] pwm
);
  logic [RES_W-1:0] cnt;
  logic             wrap;

  pwm_res_counter #(.RES_W(RES_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cnt(cnt), .wrap(wrap)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic           press;
    logic [RES_W:0] duty_pend;

    pwm_btn_sync u_sync (
      .clk(clk), .rst_n(rst_n), .btn_raw(btn[i]), .press(press)
    );

    pwm_duty_step #(.RES_W(RES_W), .STEPS(STEPS)) u_step (
      .clk(clk), .rst_n(rst_n), .press(press), .duty_pend(duty_pend)
    );

    pwm_chan_out #(.RES_W(RES_W)) u_out (
      .clk(clk), .rst_n(rst_n), .wrap(wrap), .cnt(cnt),
      .duty_pend(duty_pend), .pwm(pwm[i])
    );

    AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> $stable(pwm[i])); // R9
  end
endmodule

// File: tb/sim_pwm_multi_gen.sv
module sim_pwm_multi_gen;
  localparam int CLK_P = 10;
  localparam int NCH   = 4;
  localparam int FULL  = 256;
  localparam int STEPS = 10;

  typedef struct packed {
    logic [3:0]  mask;
    logic [15:0] exp;   // expected step index per channel, nibble i = channel i
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{4'b0001, 16'h0001},
    '{4'b0011, 16'h0012},
    '{4'b1111, 16'h1123},
    '{4'b0100, 16'h1223},
    '{4'b1000, 16'h2223},
    '{4'b0001, 16'h2224}
  };

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           tick = 1'b0;
  logic [NCH-1:0] btn = '0;
  logic [NCH-1:0] pwm;

  int total = 0;
  int bad   = 0;
  bit done  = 0;
  logic [7:0] phase;
  int model_idx [NCH];

  pwm_multi_gen u0 (.clk(clk), .rst_n(rst_n), .tick(tick), .btn(btn), .pwm(pwm));

  always #(CLK_P/2) clk = ~clk;

  // Bench-side model of the counter position (R2)
  always_ff @(posedge clk) begin
    if (!rst_n)    phase <= '0;
    else if (tick) phase <= phase + 8'd1;
  end

  function automatic int duty_of(input int idx);
    return (idx * FULL) / STEPS;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic press(input logic [NCH-1:0] mask, input int hold);
    @(negedge clk) btn = mask;
    repeat (hold) @(negedge clk);
    btn = '0;
    repeat (4) @(negedge clk);
  endtask

  // Measure one full period from counter zero; optionally press mid_mask at phase 100
  task automatic measure(input string req, input logic [NCH-1:0] mid_mask);
    int mism [NCH];
    for (int c = 0; c < NCH; c++) mism[c] = 0;
    @(negedge clk);
    while (phase != 8'd0) @(negedge clk);
    for (int s = 0; s < FULL; s++) begin
      for (int c = 0; c < NCH; c++)
        if (pwm[c] !== (int'(phase) < duty_of(model_idx[c]))) mism[c]++;
      if (s == 100) btn = mid_mask;
      if (s == 104) btn = '0;
      @(negedge clk);
    end
    for (int c = 0; c < NCH; c++)
      check(mism[c] == 0, req, mism[c], 0);
  endtask

  initial begin
    for (int c = 0; c < NCH; c++) model_idx[c] = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(pwm == '0, "R1 outputs low in reset", int'(pwm), 0);
    rst_n = 1'b1;
    tick  = 1'b1;
    @(negedge clk);
    check(pwm == '0, "R1 outputs low after reset", int'(pwm), 0);
    measure("R6 zero duty low all period", '0);

    // Table walk: R3 R4 R8
    for (int v = 0; v < 6; v++) begin
      press(VECS[v].mask, 3);
      for (int c = 0; c < NCH; c++) model_idx[c] = int'(VECS[v].exp[c*4 +: 4]);
      measure("R3 R4 R8 table step", '0);
    end

    // R4: long hold counts once (ch0 4 -> 5, duty 128)
    press(4'b0001, 40);
    model_idx[0] = 5;
    measure("R4 held press single step", '0);

    // R7: press during a period leaves that period alone
    measure("R7 period unchanged by mid press", 4'b0010);
    repeat (4) @(negedge clk);
    model_idx[1] = 3;
    measure("R7 new duty from next period", '0);

    // R6 / R5: ch3 2 -> 10 (full high), then wrap to 0
    for (int k = 0; k < 8; k++) press(4'b1000, 3);
    model_idx[3] = 10;
    measure("R6 full scale high all period", '0);
    press(4'b1000, 3);
    model_idx[3] = 0;
    measure("R5 index wraps to zero", '0);

    // R9: tick low freezes outputs
    begin
      logic [NCH-1:0] held;
      int moved = 0;
      @(negedge clk);
      while (phase != 8'd60) @(negedge clk);
      tick = 1'b0;
      held = pwm;
      repeat (30) begin
        @(negedge clk);
        if (pwm !== held) moved++;
      end
      check(moved == 0, "R9 outputs hold without tick", moved, 0);
      check(phase == 8'd60 && pwm == held, "R9 phase held", int'(pwm), int'(held));
      tick = 1'b1;
      measure("R9 R2 resume after hold", '0);
    end

    // R1: reset mid run clears every duty
    @(negedge clk) rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check(pwm == '0, "R1 mid-run reset clears outputs", int'(pwm), 0);
    rst_n = 1'b1;
    for (int c = 0; c < NCH; c++) model_idx[c] = 0;
    measure("R1 duties zero after reset", '0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule